// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog that counts on its own slow clock, separate from the register clock. A 12-bit down-counter loses one step for every 4 × 2^PR rising edges of the slow clock. PR is a 3-bit prescaler setting. If the counter is at zero when the next of those ticks arrives, the block raises a reset request for a fixed number of register clocks and reloads the counter.

Software drives the block through a single write port. That port selects one of three targets: the key register, the prescaler register or the reload register. It does not control the block with enable bits. Instead it writes fixed 16-bit key codes:

- One code starts counting.
- A second code opens the two configuration registers for writing.
- A third code reloads the counter. This is the refresh.

Any key write that is not the unlock code closes the configuration registers again. Once the watchdog is started, only a system reset stops it.

The slow clock is brought in as a plain level. The block synchronises it into the register clock domain and detects its rising edges. Status outputs show the live counter value, whether the watchdog is running, and whether the configuration registers are open.

Top module: `indep_watchdog`

## Requirements
- R1: After reset the block is stopped and locked, the reset request is low, the prescaler setting is 0 and the counter and reload value are both 0xFFF.
- R2: A write of 0xCCCC with select 0 (key) to a stopped block sets running and loads the counter from the reload register.
- R3: While running, the counter decrements by one every 4 × 2^PR synchronised rising edges of the slow clock, with PR taken from bits [2:0] of the prescaler register.
- R4: A write of 0xAAAA with select 0 reloads the counter from the reload register and restarts the prescaler when running; when stopped it leaves the counter unchanged.
- R5: Writes with select 1 (prescaler, data bits [2:0]) or select 2 (reload, data bits [11:0]) take effect only while unlocked; otherwise they are ignored.
- R6: A key write of 0x5555 unlocks the configuration registers; any other key value locks them again.
- R7: Once running, no key value clears the running state; only rstN does.
- R8: Prescaler settings 6 and 7 both divide the slow clock by 256.
- R9: When a prescaled tick finds the counter at 0, the reset request goes high on the next register clock for exactly RST_PULSE clocks, and the counter reloads from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrSel | input | 2 | Write target: 0 key, 1 prescaler, 2 reload, 3 unused |
| wrData | input | 16 | Write data |
| slowClk | input | 1 | Slow clock level, asynchronous to clk |
| count | output | 12 | Current counter value |
| running | output | 1 | High once the watchdog has been started |
| unlocked | output | 1 | High while configuration writes are accepted |
| wdgRst | output | 1 | Reset request pulse |

## Verification
A behavioural model in the bench follows the watchdog cycle by cycle under several stimulus patterns:

- **Configuration writes with the registers locked.** This shows that the lock really blocks the writes.
- **A write of a different key value.** This tells re-locking apart from a lock that stays open.
- **Free running until expiry.** This exposes errors in the divide ratio and in the length of the reset pulse.
- **Refreshes issued faster than the timeout.** This confirms that the reload actually takes effect.
- **Prescaler settings 6 and 7.** These separate a correct clamp of the divide ratio from an overflowing shift.
- **A refresh issued before start.** This distinguishes a refresh that is gated by the running state from one that reloads unconditionally.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W = 12;
  localparam int PR_W  = 3;
  localparam int KEY_W = 16;
  localparam int SEL_W = 2;
  localparam int PRE_W = 8;
  localparam int PR_MAX = 6;

  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;

  localparam logic [SEL_W-1:0] SEL_KEY = 2'd0;
  localparam logic [SEL_W-1:0] SEL_PR  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RLD = 2'd2;

  typedef struct packed {
    logic             load;
    logic             run;
    logic [PR_W-1:0]  pr;
    logic [CNT_W-1:0] rld;
  } wdgCtl_t;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [KEY_W-1:0] wrData,
  output wdgCtl_t          ctl,
  output logic             unlocked
);
  logic             runReg;
  logic [PR_W-1:0]  prReg;
  logic [CNT_W-1:0] rldReg;
  logic keyWr, startHit, refreshHit, prWr, rldWr;

  assign keyWr      = wrEn && (wrSel == SEL_KEY);
  assign startHit   = keyWr && (wrData == KEY_START);
  assign refreshHit = keyWr && (wrData == KEY_REFRESH);
  assign prWr       = wrEn && (wrSel == SEL_PR) && unlocked;
  assign rldWr      = wrEn && (wrSel == SEL_RLD) && unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg   <= 1'b0;
      unlocked <= 1'b0;
      prReg    <= '0;
      rldReg   <= '1;
    end else begin
      if (keyWr) unlocked <= (wrData == KEY_UNLOCK);
      if (startHit) runReg <= 1'b1;
      if (prWr) prReg <= wrData[PR_W-1:0];
      if (rldWr) rldReg <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    ctl.load = (startHit && !runReg) || (refreshHit && runReg);
    ctl.run  = runReg;
    ctl.pr   = prReg;
    ctl.rld  = rldReg;
  end

  // R7: running never drops while out of reset
  a_r7_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    runReg |=> runReg);
  // R5: locked reload writes leave the reload value untouched
  a_r5_locked_rld: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_RLD && !unlocked) |=> $stable(rldReg));
  // R5: locked prescaler writes leave the prescaler untouched
  a_r5_locked_pr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_PR && !unlocked) |=> $stable(prReg));
  // R6: a key other than unlock closes the registers
  a_r6_relock: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && wrData != KEY_UNLOCK) |=> !unlocked);
endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int RST_PULSE   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowClk,
  input  wdgCtl_t          ctl,
  output logic [CNT_W-1:0] count,
  output logic             wdgRst
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic [SYNC_STAGES:0] syncQ;
  logic                 slowRise;
  logic [PR_W-1:0]      shiftAmt;
  logic [PRE_W:0]       divFull;
  logic [PRE_W-1:0]     divLast;
  logic [PRE_W-1:0]     preCnt;
  logic                 preTerm, fire;
  logic [PW-1:0]        pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], slowClk};
  end
  assign slowRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  always_comb begin
    shiftAmt = (ctl.pr > PR_W'(PR_MAX)) ? PR_W'(PR_MAX) : ctl.pr;
    divFull  = (PRE_W+1)'(4) << shiftAmt;
    divLast  = PRE_W'(divFull - 1'b1);
  end

  assign preTerm = (preCnt >= divLast);
  assign fire    = !ctl.load && ctl.run && slowRise && preTerm && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '1;
    end else if (ctl.load) begin
      preCnt <= '0;
      count  <= ctl.rld;
    end else if (ctl.run && slowRise) begin
      if (preTerm) begin
        preCnt <= '0;
        count  <= (count == '0) ? ctl.rld : count - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pulseCnt <= '0;
    else if (fire)          pulseCnt <= PW'(RST_PULSE);
    else if (pulseCnt != 0) pulseCnt <= pulseCnt - 1'b1;
  end
  assign wdgRst = (pulseCnt != '0);

  // R4: a load strobe puts the reload value into the counter
  a_r4_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (count == $past(ctl.rld)));
  // R9: expiry raises the reset request and reloads the counter
  a_r9_expire: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> (wdgRst && count == $past(ctl.rld)));
  // R3: a prescaled tick steps a nonzero counter down by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && ctl.run && slowRise && preTerm && count != '0)
      |=> (count == $past(count) - 1'b1));
  // R2: a stopped, unloaded counter holds its value
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.load) |=> $stable(count));
endmodule

// File: rtl/indep_watchdog.sv
module indep_watchdog
  import wdg_pkg::*;
#(
  parameter int RST_PULSE   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [15:0] wrData,
  input  logic        slowClk,
  output logic [11:0] count,
  output logic        running,
  output logic        unlocked,
  output logic        wdgRst
);
  wdgCtl_t ctl;

  wdg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ctl(ctl), .unlocked(unlocked)
  );

  wdg_datapath #(.RST_PULSE(RST_PULSE), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .ctl(ctl),
    .count(count), .wdgRst(wdgRst)
  );

  assign running = ctl.run;
endmodule

// File: tb/indep_watchdog_tb.sv
module indep_watchdog_tb;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [15:0] wrData = '0;
  logic slowClk = 1'b0;
  logic [11:0] count;
  logic running, unlocked, wdgRst;

  int tests = 0;
  int fails = 0;
  string curReq = "R1";
  bit done = 1'b0;

  indep_watchdog #(.RST_PULSE(PULSE), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .slowClk(slowClk), .count(count), .running(running),
    .unlocked(unlocked), .wdgRst(wdgRst)
  );

  always #4 clk = ~clk;

  // slow clock: 8 register clocks per period
  int slowDiv = 0;
  always @(negedge clk) begin
    slowDiv = (slowDiv + 1) % 4;
    if (slowDiv == 0) slowClk = ~slowClk;
  end

  // behavioural reference
  int mCnt = 4095, mRld = 4095, mPr = 0, mPre = 0, mPulse = 0;
  bit mRun = 0, mUnl = 0;
  bit hist [3];
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 4095; mRld = 4095; mPr = 0; mPre = 0; mPulse = 0;
      mRun = 0; mUnl = 0;
      hist[0] = 0; hist[1] = 0; hist[2] = 0;
    end else begin
      bit rise, fired, oldRun;
      int divisor;
      rise = hist[1] && !hist[2];
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = slowClk;
      oldRun = mRun;
      fired = 0;
      divisor = 4 * (1 << ((mPr > 6) ? 6 : mPr));
      if (wrEn && wrSel == 0 &&
          ((wrData == 16'hCCCC && !oldRun) || (wrData == 16'hAAAA && oldRun))) begin
        mCnt = mRld; mPre = 0;
      end else if (oldRun && rise) begin
        if (mPre + 1 >= divisor) begin
          mPre = 0;
          if (mCnt == 0) begin mCnt = mRld; fired = 1; end
          else mCnt = mCnt - 1;
        end else mPre = mPre + 1;
      end
      if (fired) mPulse = PULSE;
      else if (mPulse > 0) mPulse = mPulse - 1;
      if (wrEn && wrSel == 0) begin
        if (wrData == 16'hCCCC) mRun = 1;
        mUnl = (wrData == 16'h5555);
      end
      if (wrEn && wrSel == 1 && mUnl) mPr = wrData[2:0];
      if (wrEn && wrSel == 2 && mUnl) mRld = wrData[11:0];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(count == mCnt[11:0], {curReq, " count"}, count, mCnt);
      chk(running == mRun, {curReq, " running"}, running, mRun);
      chk(unlocked == mUnl, {curReq, " unlocked"}, unlocked, mUnl);
      chk(wdgRst == (mPulse > 0), {curReq, " wdgRst"}, wdgRst, mPulse > 0);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    idle(3);
    rstN = 1;
    idle(1);
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timer expired actual=hung expected=finished");
    summary();
  end

  initial begin
    int hiLen;
    bit sawRst;
    doReset();
    curReq = "R1";
    chk(count == 12'hFFF && !running && !unlocked && !wdgRst, "R1 reset state", count, 4095);

    // R5: locked configuration writes are dropped
    curReq = "R5";
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd2);
    curReq = "R2";
    wr(2'd0, 16'hCCCC);
    chk(running == 1, "R2 started", running, 1);
    chk(count == 12'hFFF, "R5 locked reload ignored", count, 4095);

    // R6: unlock then relock
    curReq = "R6";
    wr(2'd0, 16'h5555);
    chk(unlocked == 1, "R6 unlocked", unlocked, 1);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h1234);
    chk(unlocked == 0, "R6 relocked", unlocked, 0);
    wr(2'd2, 16'd9);
    curReq = "R4";
    wr(2'd0, 16'hAAAA);
    chk(count == 12'd3, "R4 refresh loads reload (R5 second write ignored)", count, 3);

    // R3/R9: run to expiry with PR 0, reload 3
    curReq = "R9";
    sawRst = 0;
    for (int i = 0; i < 400 && !sawRst; i++) begin
      @(negedge clk);
      if (wdgRst) sawRst = 1;
    end
    chk(sawRst, "R9 reset request seen", sawRst, 1);
    hiLen = 1;
    while (wdgRst && hiLen < 50) begin @(negedge clk); if (wdgRst) hiLen++; end
    chk(hiLen == PULSE, "R9 pulse length", hiLen, PULSE);
    chk(count <= 12'd3, "R9 counter reloaded", count, 3);

    // R7: stray keys never stop it
    curReq = "R7";
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hCCCC);
    chk(running == 1, "R7 still running", running, 1);

    // R4: frequent refresh prevents expiry
    curReq = "R4";
    sawRst = 0;
    for (int k = 0; k < 20; k++) begin
      wr(2'd0, 16'hAAAA);
      for (int j = 0; j < 50; j++) begin @(negedge clk); if (wdgRst) sawRst = 1; end
    end
    chk(!sawRst, "R4 refresh keeps reset low", sawRst, 0);

    // R8: PR 6 and PR 7 both divide by 256
    for (int p = 6; p <= 7; p++) begin
      curReq = "R8";
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'(p));
      wr(2'd2, 16'd0);
      wr(2'd0, 16'hAAAA);
      sawRst = 0;
      for (int j = 0; j < 1900; j++) begin @(negedge clk); if (wdgRst) sawRst = 1; end
      chk(!sawRst, "R8 no expiry before 256 slow edges", sawRst, 0);
      for (int j = 0; j < 400 && !sawRst; j++) begin @(negedge clk); if (wdgRst) sawRst = 1; end
      chk(sawRst, "R8 expiry after 256 slow edges", sawRst, 1);
      idle(10);
    end

    // R3: PR 1 with reload 2 expires later than PR 0 would
    curReq = "R3";
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'hAAAA);
    idle(150);
    chk(!wdgRst, "R3 divide by 8 still counting", wdgRst, 0);
    idle(100);

    // R4: refresh before start leaves counter alone
    doReset();
    curReq = "R4";
    wr(2'd0, 16'hAAAA);
    chk(count == 12'hFFF && !running, "R4 refresh while stopped", count, 4095);
    idle(20);
    chk(count == 12'hFFF, "R1 stopped counter holds", count, 4095);

    summary();
  end
endmodule